// File: doc/BRIEF.md
# Register-Controlled SPI Master for Serial EEPROM Access

This block lets a host reach an external serial EEPROM over SPI by way of four byte-wide registers. It runs entirely in the pixel-clock domain. The host sets the chip-select and write-protect pin levels directly through a control register. It chooses the SCK rate with a two-field clock configuration register. It starts a full-duplex 8-bit exchange by writing the transmit byte. Software polls a busy flag and then reads the byte captured from the serial input.

SCK is made from the pixel clock by a power-of-two prescaler followed by a linear divider. Every SCK half period therefore lasts exactly `2^P * (D+1)` pixel clocks, which gives a 50 % duty cycle at any setting. The host owns the command protocol towards the EEPROM: it drops chip-select, sends and receives as many bytes as it needs, then raises chip-select again.

Register map (2-bit address): 0 = control (bit0 chip-select level, bit1 write-protect level); 1 = clock configuration (bits[2:0] P, bits[7:3] D); 2 = write: transmit byte and start, read: bit0 busy; 3 = read: received byte.

Top module: `spi_regmaster`

## Requirements
- R1: A write to address 0 drives `spi_cs_n` to the written bit0 from the clock edge of the write onward, with no involvement of the shift engine.
- R2: A write to address 0 drives `spi_wp_n` to the written bit1 from the clock edge of the write onward.
- R3: A write to address 2 while idle starts a transfer. The 8 transmit bits leave on `spi_sdo` most significant bit first. The first bit is presented at the start, and each later bit changes only when SCK falls.
- R4: `spi_sdi` is sampled when SCK rises. The 8 samples are packed most significant bit first, and the result can be read at address 3 once busy has cleared.
- R5: The SCK period is `2 * 2^P * (D+1)` pixel clocks, with P = address 1 bits[2:0] and D = bits[7:3]. High and low phases are equal. The first rising edge comes one half period after the start write. P=0, D=0 gives half the pixel clock, and P=7, D=31 gives 8192 clocks.
- R6: After reset, address 1 reads 0xB4 (P=4, D=22, a 736-clock period). Address 0 reads 0x01 (chip-select high, write-protect low), and addresses 2 and 3 read 0. SCK is low.
- R7: Busy (address 2 read, bit0) is 1 from the cycle after the start write. It clears 16 half periods after the start, on the same edge as the eighth SCK fall. SCK is low whenever busy is 0.
- R8: A write to address 2 while busy has no effect on the transfer in flight: its bits, its length and its received byte are unchanged.
- R9: A write to address 1 during a transfer leaves that transfer's SCK period unchanged. The new setting applies from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational on address) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data towards the EEPROM |
| spi_sdi | input | 1 | Serial data from the EEPROM |
| spi_cs_n | output | 1 | Chip-select pin level |
| spi_wp_n | output | 1 | Write-protect pin level |

## Verification
The bench builds the block with its default parameters: a 3-bit prescaler field, a 5-bit divider field and the 4/22 reset setting. This places both extremes of the divider range within reach: a half period of one clock, where SCK toggles on every edge, and a half period of 4096 clocks. Both run in a single simulation next to the 368-clock reset default. Randomly chosen small settings and byte pairs exercise the bit ordering against a bench model of the EEPROM's serial side. Writes injected mid-transfer probe the ignored-start and deferred-configuration rules.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int ADDR_W = 2;
    localparam int REG_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_CLKCFG = 2'd1,
        RA_XFER   = 2'd2,
        RA_RXDATA = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic wp_lvl;
        logic cs_lvl;
    } pin_ctrl_t;

    localparam pin_ctrl_t PIN_RESET = '{wp_lvl: 1'b0, cs_lvl: 1'b1};

    function automatic logic [REG_W-1:0] pack_ctrl(input pin_ctrl_t c);
        return {{(REG_W-2){1'b0}}, c.wp_lvl, c.cs_lvl};
    endfunction

    function automatic pin_ctrl_t unpack_ctrl(input logic [REG_W-1:0] d);
        pin_ctrl_t c;
        c.cs_lvl = d[0];
        c.wp_lvl = d[1];
        return c;
    endfunction

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
#(
    parameter int PRE_W   = 3,
    parameter int DIV_W   = 5,
    parameter int RST_PRE = 4,
    parameter int RST_DIV = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [REG_W-1:0]     host_wdata,
    output logic [REG_W-1:0]     host_rdata,
    input  logic                 busy,
    input  logic [REG_W-1:0]     rx_byte,
    output pin_ctrl_t            pins,
    output logic [PRE_W-1:0]     cfg_pre,
    output logic [DIV_W-1:0]     cfg_div,
    output logic                 start,
    output logic [REG_W-1:0]     tx_byte
);
    localparam int CFG_W = PRE_W + DIV_W;

    reg_addr_e      addr_e;
    pin_ctrl_t      pins_q;
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;

    assign addr_e = reg_addr_e'(host_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PIN_RESET;
            pre_q  <= PRE_W'(RST_PRE);
            div_q  <= DIV_W'(RST_DIV);
        end else if (host_we) begin
            if (addr_e == RA_CTRL) begin
                pins_q <= unpack_ctrl(host_wdata);
            end
            if (addr_e == RA_CLKCFG) begin
                pre_q <= host_wdata[PRE_W-1:0];
                div_q <= host_wdata[CFG_W-1:PRE_W];
            end
        end
    end

    // a start request is only honoured while the engine is idle
    assign start   = host_we && (addr_e == RA_XFER) && !busy;
    assign tx_byte = host_wdata;
    assign pins    = pins_q;
    assign cfg_pre = pre_q;
    assign cfg_div = div_q;

    always_comb begin
        host_rdata = '0;
        unique case (addr_e)
            RA_CTRL:   host_rdata = pack_ctrl(pins_q);
            RA_CLKCFG: host_rdata = REG_W'({div_q, pre_q});
            RA_XFER:   host_rdata = REG_W'(busy);
            RA_RXDATA: host_rdata = rx_byte;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_rm_clkgen.sv
module spi_rm_clkgen #(
    parameter int PRE_W = 3,
    parameter int DIV_W = 5,
    localparam int HALF_W = DIV_W + (1 << PRE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic [PRE_W-1:0]   cfg_pre,
    input  logic [DIV_W-1:0]   cfg_div,
    output logic               tick,
    output logic [HALF_W-1:0]  half_q
);
    logic [HALF_W-1:0] base;
    logic [HALF_W-1:0] half_next;
    logic [HALF_W-1:0] cnt_q;

    // half period = 2^pre * (div + 1) clocks, captured once per transfer
    always_comb begin
        base      = {{(HALF_W-DIV_W){1'b0}}, cfg_div} + HALF_W'(1);
        half_next = base << cfg_pre;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            half_q <= half_next;
            cnt_q  <= '0;
        end else if (run) begin
            if (tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + HALF_W'(1);
            end
        end
    end

    assign tick = run && (cnt_q == (half_q - HALF_W'(1)));

endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter #(
    parameter int DATA_W = 8,
    localparam int EDGES = 2 * DATA_W,
    localparam int EDGE_W = $clog2(EDGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DATA_W-1:0]  tx_byte,
    input  logic               tick,
    input  logic               sdi,
    output logic               sck,
    output logic               sdo,
    output logic               busy,
    output logic [DATA_W-1:0]  rx_byte
);
    logic              sck_q;
    logic              sdo_q;
    logic              busy_q;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_q;
    logic [EDGE_W-1:0] edge_q;
    logic              last_edge;

    assign last_edge = (edge_q == EDGE_W'(EDGES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            sdo_q  <= 1'b0;
            busy_q <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            rx_q   <= '0;
            edge_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            sck_q  <= 1'b0;
            edge_q <= '0;
            sdo_q  <= tx_byte[DATA_W-1];
            tx_sh  <= tx_byte << 1;
        end else if (busy_q && tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + EDGE_W'(1);
            if (!sck_q) begin
                // rising edge: sample the serial input
                rx_sh <= {rx_sh[DATA_W-2:0], sdi};
            end else if (last_edge) begin
                // final falling edge: transfer complete
                busy_q <= 1'b0;
                rx_q   <= rx_sh;
            end else begin
                // falling edge: present the next bit
                sdo_q <= tx_sh[DATA_W-1];
                tx_sh <= tx_sh << 1;
            end
        end
    end

    assign sck     = sck_q;
    assign sdo     = sdo_q;
    assign busy    = busy_q;
    assign rx_byte = rx_q;

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int PRE_W   = 3,
    parameter int DIV_W   = 5,
    parameter int RST_PRE = 4,
    parameter int RST_DIV = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              spi_sck,
    output logic              spi_sdo,
    input  logic              spi_sdi,
    output logic              spi_cs_n,
    output logic              spi_wp_n
);
    localparam int HALF_W = DIV_W + (1 << PRE_W);

    pin_ctrl_t          pins_w;
    logic [PRE_W-1:0]   pre_w;
    logic [DIV_W-1:0]   div_w;
    logic               start_w;
    logic [REG_W-1:0]   tx_w;
    logic [REG_W-1:0]   rx_w;
    logic               busy_w;
    logic               tick_w;
    logic [HALF_W-1:0]  half_w;

    spi_rm_regs #(
        .PRE_W   (PRE_W),
        .DIV_W   (DIV_W),
        .RST_PRE (RST_PRE),
        .RST_DIV (RST_DIV)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy_w),
        .rx_byte    (rx_w),
        .pins       (pins_w),
        .cfg_pre    (pre_w),
        .cfg_div    (div_w),
        .start      (start_w),
        .tx_byte    (tx_w)
    );

    spi_rm_clkgen #(
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .start   (start_w),
        .run     (busy_w),
        .cfg_pre (pre_w),
        .cfg_div (div_w),
        .tick    (tick_w),
        .half_q  (half_w)
    );

    spi_rm_shifter #(
        .DATA_W (REG_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start_w),
        .tx_byte (tx_w),
        .tick    (tick_w),
        .sdi     (spi_sdi),
        .sck     (spi_sck),
        .sdo     (spi_sdo),
        .busy    (busy_w),
        .rx_byte (rx_w)
    );

    assign spi_cs_n = pins_w.cs_lvl;
    assign spi_wp_n = pins_w.wp_lvl;

endmodule

// File: rtl/spi_rm_checker.sv
module spi_rm_checker #(
    parameter int HALF_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [7:0]        host_wdata,
    input logic              spi_sck,
    input logic              spi_sdo,
    input logic              spi_cs_n,
    input logic              spi_wp_n,
    input logic              busy_q,
    input logic [HALF_W-1:0] half_q
);
    logic              sck_d;
    logic [HALF_W+1:0] phase_len;

    // length of the current SCK level, in clocks
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d     <= 1'b0;
            phase_len <= '0;
        end else begin
            sck_d <= spi_sck;
            if (spi_sck != sck_d) begin
                phase_len <= (HALF_W+2)'(1);
            end else if (phase_len != '1) begin
                phase_len <= phase_len + (HALF_W+2)'(1);
            end
        end
    end

    assert_cs_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd0) |=> (spi_cs_n == $past(host_wdata[0])));

    assert_wp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd0) |=> (spi_wp_n == $past(host_wdata[1])));

    assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$fell(spi_sck)) |-> $stable(spi_sdo));

    assert_high_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (sck_d && !spi_sck) |-> (phase_len == {2'b00, half_q}));

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !spi_sck);

    assert_end_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $fell(spi_sck));

endmodule

bind spi_regmaster spi_rm_checker #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .spi_sck    (spi_sck),
    .spi_sdo    (spi_sdo),
    .spi_cs_n   (spi_cs_n),
    .spi_wp_n   (spi_wp_n),
    .busy_q     (busy_w),
    .half_q     (half_w)
);

// File: tb/spi_regmaster_tb.sv
module spi_regmaster_tb_top;

    logic       clk;
    logic       rst;
    logic       host_we;
    logic [1:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       spi_sck;
    logic       spi_sdo;
    logic       spi_sdi;
    logic       spi_cs_n;
    logic       spi_wp_n;

    int tests;
    int fails;
    int cycles;

    spi_regmaster dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .spi_sck    (spi_sck),
        .spi_sdo    (spi_sdo),
        .spi_sdi    (spi_sdi),
        .spi_cs_n   (spi_cs_n),
        .spi_wp_n   (spi_wp_n)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // ---------------- EEPROM-side serial model ----------------
    logic [7:0] slv_val;
    logic [7:0] slv_rx;
    logic [3:0] slv_fcnt;

    always @(negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) slv_fcnt <= 4'd0;
        else          slv_fcnt <= slv_fcnt + 4'd1;
    end

    assign spi_sdi = (!spi_cs_n && slv_fcnt < 4'd8) ? slv_val[3'd7 - slv_fcnt[2:0]] : 1'b0;

    always @(posedge spi_sck) slv_rx <= {slv_rx[6:0], spi_sdo};

    // ---------------- helpers ----------------
    function automatic int exp_half(input int pre, input int dv);
        return (dv + 1) << pre;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    // one full exchange; an optional register write is injected at cycle inj_k
    task automatic xfer(input int half, input logic [7:0] tx, input logic [7:0] sv,
                        input int inj_k, input logic [1:0] inj_a, input logic [7:0] inj_d,
                        input string tag);
        int k;
        int rises;
        int first_k;
        int last_k;
        int bad_per;
        int done_k;
        logic prev_sck;
        logic [7:0] rd;

        reg_write(2'd0, 8'h02);                 // select low, protect released
        check(spi_cs_n == 1'b0, "R1", {tag, " cs low after write"}, spi_cs_n, 0);
        check(spi_wp_n == 1'b1, "R2", {tag, " wp high after write"}, spi_wp_n, 1);
        slv_val = sv;

        @(negedge clk);
        host_addr  = 2'd2;
        host_wdata = tx;
        host_we    = 1'b1;
        @(negedge clk);
        host_we  = 1'b0;
        k        = 0;
        rises    = 0;
        first_k  = -1;
        last_k   = 0;
        bad_per  = 0;
        done_k   = -1;
        prev_sck = 1'b0;
        while (k <= 16 * half + 4) begin
            host_addr = 2'd2;
            host_we   = 1'b0;
            #1;
            if (k == 0) check(host_rdata[0] == 1'b1, "R7", {tag, " busy after start"}, host_rdata, 1);
            if (spi_sck && !prev_sck) begin
                rises++;
                if (rises == 1) first_k = k;
                else if (k - last_k != 2 * half) bad_per++;
                last_k = k;
            end
            if (!host_rdata[0]) begin
                done_k = k;
                break;
            end
            if (k == inj_k) begin
                host_addr  = inj_a;
                host_wdata = inj_d;
                host_we    = 1'b1;
            end
            prev_sck = spi_sck;
            @(negedge clk);
            k++;
        end
        host_we = 1'b0;

        check(done_k == 16 * half, "R7", {tag, " busy duration"}, done_k, 16 * half);
        check(first_k == half, "R5", {tag, " first rise"}, first_k, half);
        check(bad_per == 0 && rises == 8, "R5", {tag, " sck period/count"}, rises, 8);
        check(slv_rx == tx, "R3", {tag, " bits seen by slave"}, slv_rx, tx);
        reg_read(2'd3, rd);
        check(rd == sv, "R4", {tag, " received byte"}, rd, sv);
        check(spi_sck == 1'b0, "R7", {tag, " sck idle"}, spi_sck, 0);
        reg_write(2'd0, 8'h01);
        check(spi_cs_n == 1'b1, "R1", {tag, " cs high after write"}, spi_cs_n, 1);
        check(spi_wp_n == 1'b0, "R2", {tag, " wp low after write"}, spi_wp_n, 0);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] rd;
        int seed;
        tests      = 0;
        fails      = 0;
        cycles     = 0;
        seed       = 1234;
        void'($urandom(seed));
        slv_val    = 8'h00;
        host_we    = 1'b0;
        host_addr  = 2'd0;
        host_wdata = 8'h00;
        rst        = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6 reset state
        reg_read(2'd0, rd); check(rd == 8'h01, "R6", "ctrl reset", rd, 8'h01);
        reg_read(2'd1, rd); check(rd == 8'hB4, "R6", "clkcfg reset", rd, 8'hB4);
        reg_read(2'd2, rd); check(rd == 8'h00, "R6", "status reset", rd, 0);
        reg_read(2'd3, rd); check(rd == 8'h00, "R6", "rx reset", rd, 0);
        check(spi_sck == 1'b0 && spi_cs_n == 1'b1 && spi_wp_n == 1'b0, "R6", "pins reset",
              {spi_sck, spi_cs_n, spi_wp_n}, 3'b010);

        // R6 default rate: 736-clock period
        xfer(exp_half(4, 22), 8'hA5, 8'h3C, -1, 2'd0, 8'h00, "R6 default");

        // R5 fastest setting
        reg_write(2'd1, {5'd0, 3'd0});
        xfer(exp_half(0, 0), 8'h81, 8'h7E, -1, 2'd0, 8'h00, "R5 fastest");

        // R8 start write while busy is ignored
        reg_write(2'd1, {5'd2, 3'd1});
        xfer(exp_half(1, 2), 8'hC3, 8'h5A, 3, 2'd2, 8'h3C, "R8 busy write");

        // R9 clock change mid-transfer deferred
        reg_write(2'd1, {5'd1, 3'd0});
        xfer(exp_half(0, 1), 8'h96, 8'hE1, 5, 2'd1, {5'd2, 3'd1}, "R9 during");
        reg_read(2'd1, rd); check(rd == 8'h11, "R9", "new clkcfg stored", rd, 8'h11);
        xfer(exp_half(1, 2), 8'h0F, 8'hF0, -1, 2'd0, 8'h00, "R9 next");

        // random small settings and data (R3/R4/R5)
        for (int i = 0; i < 6; i++) begin
            int p;
            int d;
            logic [7:0] t;
            logic [7:0] s;
            p = int'($urandom % 3);
            d = int'($urandom % 8);
            t = 8'($urandom);
            s = 8'($urandom);
            reg_write(2'd1, {5'(d), 3'(p)});
            xfer(exp_half(p, d), t, s, -1, 2'd0, 8'h00, "R3 R4 random");
        end

        // R5 slowest setting: 8192-clock period
        reg_write(2'd1, {5'd31, 3'd7});
        xfer(exp_half(7, 31), 8'h6D, 8'hB2, -1, 2'd0, 8'h00, "R5 slowest");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule